// File: doc/BRIEF.md
# Two-Stage Strobe DLL Loop Controller

This block is the digital loop filter that steers the two cascaded delay lines of a strobe-path delay-locked loop. The first loop delivers one phase-detector bit. The second loop delivers a pair of bits, one sampled against the true reference edge and one against the complement edge. Each delay line takes a six-tap thermometer coarse word and a four-bit interpolator word. Internally the controller keeps one linear code per loop, counted in interpolator steps, and splits it into those two fields.

After reset or a start pulse, both codes sit at zero. The first update slot records each loop's detector value as that loop's lock reference. A loop with sweep enabled then climbs in whole coarse taps until its detector pattern changes or its coarse field is full. Once every enabled sweep has ended, both loops step together on every slot, in a direction chosen by comparing the live detector value with the recorded reference. The step size is selected per loop. The controller raises a lock flag once both loops have reversed direction on a long enough run of consecutive updates.

Top module: `dll_lf_top`

## Requirements
- R1: While reset is low, and in the cycle after a start pulse, both coarse outputs are 000000, both fine outputs are 0 and `locked_o` is low.
- R2: Decisions are taken only on update slots, one every 8 clocks. The first slot falls on the 8th rising edge after reset release or after the edge that sampled `start_i`. A slot acts on the detector value present two rising edges earlier, because the detector inputs pass through a two-flop synchronizer.
- R3: The first slot only records each loop's detector value as its reference, and the codes stay at zero.
- R4: When loop 1 is tracking, its code rises by the gain if `pd1_i` equals the recorded bit, and falls by the gain otherwise.
- R5: Loop 2 targets the complement edge when its recorded pair `pd2_i` was 2'b10, and the true edge for any other recorded pair. The complement edge compares bit 0 and the true edge compares bit 1. The code rises by the gain when the live bit at that position equals the recorded bit at the same position, and falls otherwise.
- R6: A gain select of 0, 1, 2 or 3 gives a step of 1, 2, 4 or 8 fine units. Each loop has its own select, read on every slot.
- R7: A linear code L maps to coarse count n = min(floor(L/15), 6), and the n low bits of the coarse output are set. The fine output is L - 15n, so it reaches 15 only when all six coarse bits are set.
- R8: L saturates at 0 and at 105 (coarse 111111, fine 15) and never wraps.
- R9: For a loop whose sweep enable is set at the first slot, each later slot adds 15 to L while the live detector pattern equals the recorded one and the coarse field is not full. The sweep ends without a step on the first slot where the pattern differs or the field is full.
- R10: Neither loop tracks until every enabled sweep has ended. From the next slot on, both loops step on the same slot. A loop without sweep holds zero meanwhile.
- R11: `locked_o` rises after 16 consecutive tracking slots in which both loops step opposite to their previous step. The first tracking slot never counts as a reversal. Once high, the flag stays high until reset or a start pulse.
- R12: A start pulse restarts the whole sequence. The next slots record new references, and sweep enables are taken again at the recording slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that restarts the lock sequence |
| pd1_i | input | 1 | Loop 1 phase-detector bit (asynchronous) |
| pd2_i | input | 2 | Loop 2 detector pair: bit 1 against the true edge, bit 0 against the complement edge |
| sweep_en_i | input | 2 | Coarse sweep enable; bit 0 for loop 1, bit 1 for loop 2 |
| gain1_sel_i | input | 2 | Loop 1 step select (1, 2, 4, 8) |
| gain2_sel_i | input | 2 | Loop 2 step select (1, 2, 4, 8) |
| coarse1_o | output | 6 | Loop 1 coarse thermometer word |
| fine1_o | output | 4 | Loop 1 interpolator word |
| coarse2_o | output | 6 | Loop 2 coarse thermometer word |
| fine2_o | output | 4 | Loop 2 interpolator word |
| locked_o | output | 1 | Sticky lock indication |

## Verification
The assertions rely on three conditions. `start_i` is the only source of a mid-run restart. The configuration inputs stay constant between start pulses. Code changes can therefore be tied to update slots or to a start pulse, and a cleared lock flag always follows a start pulse. The bench drives every input on falling clock edges and holds the detector values for a full slot. It moves a detector input close to a slot edge only in the one test that probes synchronizer latency. It also changes gains and sweep enables only before issuing a start pulse.

// File: rtl/dll_lf_pkg.sv
// Package: shared types for the cascaded DLL loop controller.
// Assumes: nothing beyond being compiled before the modules that import it.
package dll_lf_pkg;

    // Sequence phase shared by both loops.
    typedef enum logic [1:0] {
        PH_CAPTURE = 2'd0,
        PH_SWEEP   = 2'd1,
        PH_TRACK   = 2'd2
    } phase_e;

endpackage

// File: rtl/dll_lf_sync.sv
// Module: multi-bit, multi-stage flop synchronizer for detector samples.
// Assumes: the bits are independent; no bus coherency is needed, because
// each bit is a separate sampler output that settles over a slot.
module dll_lf_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dll_lf_lane.sv
// Module: code register and decision logic for one delay line.
// It holds a linear code in fine units, records a detector reference,
// runs the optional coarse sweep and applies the tracking step.
// PD_W selects the detector variant: 1 (single bit) or 2 (true/complement pair).
// Assumes: at most one of capture_i, sweep_i and track_i is high in a cycle,
// and restart_i takes priority over all of them.
module dll_lf_lane #(
    parameter  int PD_W        = 1,
    parameter  int COARSE_TAPS = 6,
    parameter  int FINE_STEPS  = 15,
    parameter  int GAIN_W      = 2,
    localparam int FINE_W      = $clog2(FINE_STEPS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart_i,
    input  logic                   capture_i,
    input  logic                   sweep_i,
    input  logic                   track_i,
    input  logic                   sweep_en_i,
    input  logic [GAIN_W-1:0]      gain_sel_i,
    input  logic [PD_W-1:0]        pd_i,
    output logic [COARSE_TAPS-1:0] coarse_o,
    output logic [FINE_W-1:0]      fine_o,
    output logic                   done_o,
    output logic                   up_o
);

    localparam int CODE_MAX = COARSE_TAPS * FINE_STEPS + FINE_STEPS;
    localparam int CODE_W   = $clog2(CODE_MAX + 1);
    localparam logic [CODE_W:0] MAX_X = (CODE_W + 1)'(CODE_MAX);

    logic [CODE_W-1:0]      code_q;
    logic [PD_W-1:0]        ref_q;
    logic                   done_q;
    logic                   live_bit;
    logic                   ref_bit;
    logic [CODE_W:0]        code_x;
    logic [CODE_W:0]        step_w;
    logic [CODE_W:0]        up_sum;
    logic [CODE_W-1:0]      up_val;
    logic [CODE_W-1:0]      dn_val;
    logic [CODE_W-1:0]      sweep_val;
    logic [CODE_W-1:0]      base;
    logic [COARSE_TAPS-1:0] therm;
    logic                   at_top;
    logic                   flip;

    // Pick the compared detector bit according to the detector variant.
    generate
        if (PD_W == 1) begin : g_single
            assign live_bit = pd_i[0];
            assign ref_bit  = ref_q[0];
        end else begin : g_pair
            logic use_comp;
            assign use_comp = ref_q[1] & ~ref_q[0];
            assign live_bit = use_comp ? pd_i[0]  : pd_i[1];
            assign ref_bit  = use_comp ? ref_q[0] : ref_q[1];
        end
    endgenerate

    assign up_o = (live_bit == ref_bit);
    assign flip = (pd_i != ref_q);

    // Saturating arithmetic on the linear code.
    assign code_x    = {1'b0, code_q};
    assign step_w    = (CODE_W + 1)'(1) << gain_sel_i;
    assign up_sum    = code_x + step_w;
    assign up_val    = (up_sum > MAX_X) ? CODE_W'(CODE_MAX) : up_sum[CODE_W-1:0];
    assign dn_val    = (code_x >= step_w) ? CODE_W'(code_x - step_w) : '0;
    assign sweep_val = CODE_W'(code_x + (CODE_W + 1)'(FINE_STEPS));

    // One comparator per coarse tap builds the thermometer word.
    for (genvar k = 0; k < COARSE_TAPS; k++) begin : g_therm
        assign therm[k] = (code_q >= CODE_W'((k + 1) * FINE_STEPS));
    end

    assign at_top = therm[COARSE_TAPS-1];

    // Linear offset of the highest coarse tap reached, for the fine remainder.
    always_comb begin
        base = '0;
        for (int k = 0; k < COARSE_TAPS; k++) begin
            if (therm[k]) base = CODE_W'((k + 1) * FINE_STEPS);
        end
    end

    assign coarse_o = therm;
    assign fine_o   = FINE_W'(code_q - base);
    assign done_o   = done_q | (sweep_i & (flip | at_top));

    // Sequence the code through capture, sweep and tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            code_q <= '0;
            ref_q  <= '0;
            done_q <= 1'b0;
        end else if (capture_i) begin
            ref_q  <= pd_i;
            code_q <= '0;
            done_q <= ~sweep_en_i;
        end else if (sweep_i && !done_q) begin
            if (flip || at_top) done_q <= 1'b1;
            else                code_q <= sweep_val;
        end else if (track_i) begin
            code_q <= up_o ? up_val : dn_val;
        end
    end

endmodule

// File: rtl/dll_lf_lock.sv
// Module: lock detector that counts consecutive direction reversals.
// Assumes: up1_i and up2_i are valid in every cycle where track_i is high.
module dll_lf_lock #(
    parameter int LOCK_RUN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic track_i,
    input  logic up1_i,
    input  logic up2_i,
    output logic locked_o
);

    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    logic [RUN_W-1:0] run_q;
    logic             prev1_q;
    logic             prev2_q;
    logic             seen_q;
    logic             locked_q;
    logic             reversed;

    assign reversed = seen_q & (up1_i != prev1_q) & (up2_i != prev2_q);

    // Count reversals, remember the last direction and set the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            run_q    <= '0;
            prev1_q  <= 1'b0;
            prev2_q  <= 1'b0;
            seen_q   <= 1'b0;
            locked_q <= 1'b0;
        end else if (track_i) begin
            seen_q  <= 1'b1;
            prev1_q <= up1_i;
            prev2_q <= up2_i;
            if (reversed) begin
                if (run_q != RUN_W'(LOCK_RUN))   run_q    <= run_q + 1'b1;
                if (run_q == RUN_W'(LOCK_RUN - 1)) locked_q <= 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end

    assign locked_o = locked_q;

endmodule

// File: rtl/dll_lf_top.sv
// Module: loop filter for two cascaded strobe-path delay lines.
// It synchronizes the detectors, divides the clock into update slots,
// sequences capture, sweep and tracking, and reports lock.
// Assumes: start_i is a single-cycle pulse, and the sweep enables and gains
// are quasi-static configuration.
module dll_lf_top
    import dll_lf_pkg::*;
#(
    parameter  int COARSE_TAPS = 6,
    parameter  int FINE_STEPS  = 15,
    parameter  int GAIN_W      = 2,
    parameter  int SLOT_CLKS   = 8,
    parameter  int LOCK_RUN    = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int FINE_W      = $clog2(FINE_STEPS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   pd1_i,
    input  logic [1:0]             pd2_i,
    input  logic [1:0]             sweep_en_i,
    input  logic [GAIN_W-1:0]      gain1_sel_i,
    input  logic [GAIN_W-1:0]      gain2_sel_i,
    output logic [COARSE_TAPS-1:0] coarse1_o,
    output logic [FINE_W-1:0]      fine1_o,
    output logic [COARSE_TAPS-1:0] coarse2_o,
    output logic [FINE_W-1:0]      fine2_o,
    output logic                   locked_o
);

    localparam int SLOT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    logic [SLOT_W-1:0] slot_q;
    logic              slot_tick;
    phase_e            phase_q;
    logic [2:0]        pd_sync;
    logic              cap_go;
    logic              swp_go;
    logic              trk_go;
    logic              done1;
    logic              done2;
    logic              up1;
    logic              up2;

    dll_lf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({pd2_i, pd1_i}),
        .q_o   (pd_sync)
    );

    // Free-running slot divider, realigned by a start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)  slot_q <= '0;
        else if (slot_tick)     slot_q <= '0;
        else                    slot_q <= slot_q + 1'b1;
    end

    assign slot_tick = (slot_q == SLOT_W'(SLOT_CLKS - 1));

    // Phase sequencer: capture, then optional sweep, then tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            phase_q <= PH_CAPTURE;
        end else if (slot_tick) begin
            case (phase_q)
                PH_CAPTURE: phase_q <= (|sweep_en_i) ? PH_SWEEP : PH_TRACK;
                PH_SWEEP:   if (done1 && done2) phase_q <= PH_TRACK;
                default:    phase_q <= PH_TRACK;
            endcase
        end
    end

    assign cap_go = slot_tick && (phase_q == PH_CAPTURE);
    assign swp_go = slot_tick && (phase_q == PH_SWEEP);
    assign trk_go = slot_tick && (phase_q == PH_TRACK);

    dll_lf_lane #(
        .PD_W(1), .COARSE_TAPS(COARSE_TAPS), .FINE_STEPS(FINE_STEPS), .GAIN_W(GAIN_W)
    ) u_lane1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (start_i),
        .capture_i  (cap_go),
        .sweep_i    (swp_go),
        .track_i    (trk_go),
        .sweep_en_i (sweep_en_i[0]),
        .gain_sel_i (gain1_sel_i),
        .pd_i       (pd_sync[0]),
        .coarse_o   (coarse1_o),
        .fine_o     (fine1_o),
        .done_o     (done1),
        .up_o       (up1)
    );

    dll_lf_lane #(
        .PD_W(2), .COARSE_TAPS(COARSE_TAPS), .FINE_STEPS(FINE_STEPS), .GAIN_W(GAIN_W)
    ) u_lane2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (start_i),
        .capture_i  (cap_go),
        .sweep_i    (swp_go),
        .track_i    (trk_go),
        .sweep_en_i (sweep_en_i[1]),
        .gain_sel_i (gain2_sel_i),
        .pd_i       (pd_sync[2:1]),
        .coarse_o   (coarse2_o),
        .fine_o     (fine2_o),
        .done_o     (done2),
        .up_o       (up2)
    );

    dll_lf_lock #(.LOCK_RUN(LOCK_RUN)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .track_i   (trk_go),
        .up1_i     (up1),
        .up2_i     (up2),
        .locked_o  (locked_o)
    );

endmodule

// File: rtl/dll_lf_checks.sv
// Module: property checker bound to dll_lf_top.
// Assumes: start_i is the only mid-run restart source.
module dll_lf_checks
    import dll_lf_pkg::*;
#(
    parameter  int COARSE_TAPS = 6,
    parameter  int FINE_STEPS  = 15,
    localparam int FINE_W      = $clog2(FINE_STEPS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   slot_tick,
    input phase_e                 phase,
    input logic [COARSE_TAPS-1:0] coarse1,
    input logic [FINE_W-1:0]      fine1,
    input logic [COARSE_TAPS-1:0] coarse2,
    input logic [FINE_W-1:0]      fine2,
    input logic                   locked
);

    // R1: a start pulse leaves all codes at zero and lock low.
    a_r1_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i) |-> (coarse1 == '0 && fine1 == '0 && coarse2 == '0 && fine2 == '0 && !locked));

    // R3: the codes stay at minimum during the capture phase.
    a_r3_zero_while_capturing: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CAPTURE) |-> (coarse1 == '0 && fine1 == '0 && coarse2 == '0 && fine2 == '0));

    // R2: the codes move only after an update slot or a start pulse.
    a_r2_change_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({coarse1, fine1, coarse2, fine2}) |-> ($past(slot_tick) || $past(start_i)));

    // R7: both coarse words are thermometer shaped.
    a_r7_thermometer_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ((coarse1 & (coarse1 + 1'b1)) == '0) && ((coarse2 & (coarse2 + 1'b1)) == '0));

    // R8: the fine field reaches 15 only with the coarse field full (loop 1).
    a_r8_fine_bound1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fine1) >= FINE_STEPS) |-> (&coarse1));

    // R8: the same bound for loop 2.
    a_r8_fine_bound2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fine2) >= FINE_STEPS) |-> (&coarse2));

    // R9: sweeping moves only whole coarse taps.
    a_r9_sweep_whole_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SWEEP) |-> (fine1 == '0 && fine2 == '0));

    // R11: lock is sticky until a start pulse.
    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked) && !$past(start_i)) |-> locked);

endmodule

bind dll_lf_top dll_lf_checks #(
    .COARSE_TAPS (COARSE_TAPS),
    .FINE_STEPS  (FINE_STEPS)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .slot_tick (slot_tick),
    .phase     (phase_q),
    .coarse1   (coarse1_o),
    .fine1     (fine1_o),
    .coarse2   (coarse2_o),
    .fine2     (fine2_o),
    .locked    (locked_o)
);

// File: tb/dll_lf_top_test.sv
`timescale 1ns/1ps
module dll_lf_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pd1_i = 1'b0;
    logic [1:0] pd2_i = 2'b00;
    logic [1:0] sweep_en_i = 2'b00;
    logic [1:0] gain1_sel_i = 2'd0;
    logic [1:0] gain2_sel_i = 2'd0;
    logic [5:0] coarse1_o;
    logic [3:0] fine1_o;
    logic [5:0] coarse2_o;
    logic [3:0] fine2_o;
    logic       locked_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    dll_lf_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pd1_i       (pd1_i),
        .pd2_i       (pd2_i),
        .sweep_en_i  (sweep_en_i),
        .gain1_sel_i (gain1_sel_i),
        .gain2_sel_i (gain2_sel_i),
        .coarse1_o   (coarse1_o),
        .fine1_o     (fine1_o),
        .coarse2_o   (coarse2_o),
        .fine2_o     (fine2_o),
        .locked_o    (locked_o)
    );

    // Tracking vectors: {pd1, pd2, coarse1, fine1, coarse2, fine2}.
    // Loop 1 gain 4, loop 2 gain 1, both references recorded as 0 / 2'b00.
    localparam logic [22:0] TRACK_VEC [0:6] = '{
        {1'b0, 2'b00, 6'b000000, 4'd4,  6'b000000, 4'd1},
        {1'b0, 2'b00, 6'b000000, 4'd8,  6'b000000, 4'd2},
        {1'b0, 2'b00, 6'b000000, 4'd12, 6'b000000, 4'd3},
        {1'b0, 2'b01, 6'b000001, 4'd1,  6'b000000, 4'd4},
        {1'b1, 2'b10, 6'b000000, 4'd12, 6'b000000, 4'd3},
        {1'b1, 2'b11, 6'b000000, 4'd8,  6'b000000, 4'd2},
        {1'b0, 2'b00, 6'b000000, 4'd12, 6'b000000, 4'd3}
    };

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic slot();
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_codes(input string req, input logic [5:0] c1, input logic [3:0] f1,
                               input logic [5:0] c2, input logic [3:0] f2);
        checks++;
        if (coarse1_o !== c1 || fine1_o !== f1 || coarse2_o !== c2 || fine2_o !== f2) begin
            fails++;
            $display("FAIL %s: actual c1=%b f1=%0d c2=%b f2=%0d expected c1=%b f1=%0d c2=%b f2=%0d",
                     req, coarse1_o, fine1_o, coarse2_o, fine2_o, c1, f1, c2, f2);
        end
    endtask

    task automatic check_lock(input string req, input logic exp);
        checks++;
        if (locked_o !== exp) begin
            fails++;
            $display("FAIL %s: actual locked=%b expected locked=%b", req, locked_o, exp);
        end
    endtask

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_codes("R1 reset", 6'b0, 4'd0, 6'b0, 4'd0);
        check_lock("R1 reset", 1'b0);

        // Vector table: loop 1 gain 4, loop 2 gain 1, no sweep.
        gain1_sel_i = 2'd2;
        gain2_sel_i = 2'd0;
        rst_n = 1'b1;
        slot();
        check_codes("R3 capture keeps zero", 6'b0, 4'd0, 6'b0, 4'd0);
        for (int i = 0; i < 7; i++) begin
            pd1_i = TRACK_VEC[i][22];
            pd2_i = TRACK_VEC[i][21:20];
            if (i == 0) begin
                repeat (7) @(negedge clk);
                check_codes("R2 no step before slot", 6'b0, 4'd0, 6'b0, 4'd0);
                @(negedge clk);
            end else begin
                slot();
            end
            check_codes("R4 R5 R6 R7 table", TRACK_VEC[i][19:14], TRACK_VEC[i][13:10],
                        TRACK_VEC[i][9:4], TRACK_VEC[i][3:0]);
            check_lock("R11 no lock yet", 1'b0);
        end

        // Non-reversing slot resets the run, then 16 reversals.
        pd1_i = 1'b0; pd2_i = 2'b00;
        slot();
        check_codes("R4 run reset step", 6'b000001, 4'd1, 6'b0, 4'd4);
        for (int k = 1; k <= 16; k++) begin
            pd1_i = (k % 2 == 1);
            pd2_i = (k % 2 == 1) ? 2'b10 : 2'b00;
            slot();
            if (k % 2 == 1) check_codes("R11 alternate down", 6'b0, 4'd12, 6'b0, 4'd3);
            else            check_codes("R11 alternate up", 6'b000001, 4'd1, 6'b0, 4'd4);
            if (k == 15) check_lock("R11 15 reversals", 1'b0);
            if (k == 16) check_lock("R11 16 reversals", 1'b1);
        end
        slot();
        check_codes("R4 step after lock", 6'b000001, 4'd5, 6'b0, 4'd5);
        check_lock("R11 sticky", 1'b1);

        // Saturation with gain 8 on both loops.
        gain1_sel_i = 2'd3;
        gain2_sel_i = 2'd3;
        pd1_i = 1'b0; pd2_i = 2'b00;
        pulse_start();
        check_codes("R12 start clears codes", 6'b0, 4'd0, 6'b0, 4'd0);
        check_lock("R12 start clears lock", 1'b0);
        slot();
        check_codes("R3 recapture", 6'b0, 4'd0, 6'b0, 4'd0);
        pd2_i = 2'b10;
        repeat (13) slot();
        check_codes("R7 R8 near top and floor", 6'b111111, 4'd14, 6'b0, 4'd0);
        slot();
        check_codes("R8 top saturation", 6'b111111, 4'd15, 6'b0, 4'd0);
        slot();
        check_codes("R8 top held", 6'b111111, 4'd15, 6'b0, 4'd0);
        pd1_i = 1'b1;
        repeat (13) slot();
        check_codes("R8 descend", 6'b0, 4'd1, 6'b0, 4'd0);
        slot();
        check_codes("R8 floor saturation", 6'b0, 4'd0, 6'b0, 4'd0);

        // Complement-edge target on loop 2, gain 2 on loop 1.
        gain1_sel_i = 2'd1;
        gain2_sel_i = 2'd0;
        pd1_i = 1'b0; pd2_i = 2'b10;
        pulse_start();
        slot();
        pd2_i = 2'b00;
        slot();
        check_codes("R5 R6 complement up", 6'b0, 4'd2, 6'b0, 4'd1);
        pd2_i = 2'b11;
        slot();
        check_codes("R5 complement down", 6'b0, 4'd4, 6'b0, 4'd0);
        // Late detector change: the synchronizer hides it from this slot.
        repeat (7) @(negedge clk);
        pd1_i = 1'b1;
        @(negedge clk);
        check_codes("R2 sync latency", 6'b0, 4'd6, 6'b0, 4'd0);
        slot();
        check_codes("R2 R4 after sync", 6'b0, 4'd4, 6'b0, 4'd0);

        // Loop 1 sweep ending on a detector flip.
        gain1_sel_i = 2'd0;
        sweep_en_i = 2'b01;
        pd1_i = 1'b0; pd2_i = 2'b00;
        pulse_start();
        slot();
        check_codes("R3 capture with sweep", 6'b0, 4'd0, 6'b0, 4'd0);
        slot();
        check_codes("R9 R10 sweep tap 1", 6'b000001, 4'd0, 6'b0, 4'd0);
        slot();
        check_codes("R9 sweep tap 2", 6'b000011, 4'd0, 6'b0, 4'd0);
        pd1_i = 1'b1;
        slot();
        check_codes("R9 flip ends sweep", 6'b000011, 4'd0, 6'b0, 4'd0);
        slot();
        check_codes("R10 joint tracking", 6'b000001, 4'd14, 6'b0, 4'd1);

        // Loop 2 sweep running out of coarse taps.
        sweep_en_i = 2'b10;
        pd1_i = 1'b0; pd2_i = 2'b01;
        pulse_start();
        slot();
        for (int j = 1; j <= 6; j++) begin
            slot();
            check_codes("R9 R10 loop 2 sweep", 6'b0, 4'd0, 6'((1 << j) - 1), 4'd0);
        end
        slot();
        check_codes("R9 sweep ends at full coarse", 6'b0, 4'd0, 6'b111111, 4'd0);
        slot();
        check_codes("R10 R7 track after full sweep", 6'b0, 4'd1, 6'b111111, 4'd1);

        // Reset in mid-run.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_codes("R1 mid-run reset", 6'b0, 4'd0, 6'b0, 4'd0);
        check_lock("R1 mid-run reset", 1'b0);

        finish_run();
    end

endmodule